// File: doc/BRIEF.md
# Daisy-Chain LED Packet Sequencer

This block drives the serial data line and the shift clock of a chain of cascaded constant-current LED drivers. The host passes in one 218-bit payload at a time over a valid/ready handshake. The packet for the device at the far end of the chain comes first. The block puts a fixed 6-bit write command in front of each payload and sends the resulting 224-bit word MSB first. It joins the words for all `NUM_DEV` devices into one unbroken stream. When the last bit is out, it holds the clock still long enough for every device to copy its shift register into its latch.

The shift clock comes from the system clock. Each half period lasts `HALF_CYC` system cycles, and data changes only while the clock is low. A two-bit mode, sampled when a frame starts, decides what happens after the latch idle. In internal-oscillator mode the clock simply stays stopped. In the two external grayscale-clock modes the block first waits a settling time. That time is given in picoseconds and rounded up to whole system cycles. The block then sends grayscale clocks with data held low. In short-chain mode it sends a full display period of `GS_COUNT` clocks. In long-chain mode it sends only the lead-in that, added to the next frame's data clocks, makes up one display period.

Top module: `ledchain_sequencer`

## Requirements
- R1: Straight after reset the shift clock is low, the data line is low and `pktReady` is high.
- R2: A payload is taken on a cycle where `pktValid` and `pktReady` are both high. The single buffer then shows `pktReady` low from the next cycle until that payload moves into the shifter.
- R3: Each packet goes out MSB first as 224 bits: the write command 100101 (binary), then `pktData[217]` down to `pktData[0]`. The device samples each bit on a rising clock edge.
- R4: A frame begins once a payload is buffered while the block is idle. Exactly `NUM_DEV` packets are sent in the order they were accepted. When the next payload is already buffered, consecutive rising edges are exactly 2×`HALF_CYC` system cycles apart, across packet boundaries too.
- R5: The clock stays high for exactly `HALF_CYC` cycles each period, and the data line never changes while the clock is high.
- R6: If no payload is buffered at a packet boundary inside a frame, the clock stays low until one arrives. The stream then carries on without losing or repeating a bit.
- R7: After the final data bit, the clock and the data line stay low for at least 8×2×`HALF_CYC` cycles beyond the last clock period.
- R8: Mode 00 (internal oscillator), and mode 11 treated the same way, sends no clock after the latch idle until the next frame.
- R9: Mode 01 (short external chain) waits at least ceil(`SETTLE_PS`/`SYS_PERIOD_PS`) cycles after the latch idle. It then sends `GS_COUNT` clocks with data low and goes idle.
- R10: Mode 10 (long external chain) sends `GS_COUNT` − 224×`NUM_DEV` clocks with data low after the settling wait. It then starts the next frame as soon as a payload is buffered, so lead-in plus data clocks total `GS_COUNT`.
- R11: The mode is sampled when a frame starts. A change to `modeSel` during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 2 | 00/11 internal oscillator, 01 short external chain, 10 long external chain |
| pktValid | input | 1 | Payload on `pktData` is valid |
| pktData | input | 218 | Payload for one device, MSB sent first |
| pktReady | output | 1 | Single payload buffer is empty |
| sclkOut | output | 1 | Shift clock to the first device |
| sdoOut | output | 1 | Serial data to the first device |

## Verification
The stream is tried with back-to-back payloads, which show whether the packet boundary causes a gap or an extra clock. It is also tried with a late second payload, which separates a clean stall from a lost or repeated bit. Each mode runs its own frame: the trailing-clock count and the spacing after the latch idle distinguish internal, short-chain and long-chain behaviour. Mode 11 and a mode change in the middle of a frame show that the mode is decoded and sampled only at the frame start.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;
  localparam int PKT_BITS = 224;
  localparam int HDR_BITS = 6;
  localparam int PAY_BITS = PKT_BITS - HDR_BITS;
  localparam logic [HDR_BITS-1:0] WRITE_CMD = 6'b100101;

  typedef enum logic [1:0] {
    MODE_INTOSC     = 2'b00,
    MODE_EXT_SHORT  = 2'b01,
    MODE_EXT_LONG   = 2'b10,
    MODE_INTOSC_ALT = 2'b11
  } chainMode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SHIFT,
    PH_STALL,
    PH_LATCH,
    PH_SETTLE,
    PH_GSCLK
  } chainPhase_e;

  typedef struct packed {
    logic loadPkt;
    logic shiftBit;
  } dpStrobe_t;
endpackage

// File: rtl/ledchain_sclk_gen.sv
module ledchain_sclk_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic sclk,
  output logic fallEv
);
  localparam int DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DW-1:0] divCnt;
  logic          sclkQ;
  logic          edgeDue;

  assign edgeDue = run && (divCnt == DW'(HALF_CYC - 1));
  assign fallEv  = edgeDue && sclkQ;
  assign sclk    = sclkQ;

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      divCnt <= '0;
      sclkQ  <= 1'b0;
    end else if (edgeDue) begin
      divCnt <= '0;
      sclkQ  <= ~sclkQ;
    end else begin
      divCnt <= divCnt + DW'(1);
    end
  end
endmodule

// File: rtl/ledchain_datapath.sv
module ledchain_datapath
  import ledchain_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                pktValid,
  input  logic [PAY_BITS-1:0] pktData,
  input  dpStrobe_t           strobe,
  output logic                pktReady,
  output logic                bufFull,
  output logic                sdo
);
  logic [PAY_BITS-1:0] bufQ;
  logic                fullQ;
  logic [PKT_BITS-1:0] shiftQ;
  logic                take;

  assign take     = pktValid && !fullQ;
  assign pktReady = !fullQ;
  assign bufFull  = fullQ;
  assign sdo      = shiftQ[PKT_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ <= 1'b0;
      bufQ  <= '0;
    end else if (take) begin
      fullQ <= 1'b1;
      bufQ  <= pktData;
    end else if (strobe.loadPkt) begin
      fullQ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strobe.loadPkt) begin
      shiftQ <= {WRITE_CMD, bufQ};
    end else if (strobe.shiftBit) begin
      shiftQ <= {shiftQ[PKT_BITS-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/ledchain_ctrl.sv
module ledchain_ctrl
  import ledchain_pkg::*;
#(
  parameter int NUM_DEV      = 256,
  parameter int HALF_CYC     = 4,
  parameter int IDLE_PERIODS = 8,
  parameter int SETTLE_CYC   = 134,
  parameter int GS_COUNT     = 65536,
  parameter int LEAD_COUNT   = 8192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeIn,
  input  logic        bufFull,
  input  logic        fallEv,
  output logic        run,
  output dpStrobe_t   strobe,
  output chainPhase_e phase
);
  localparam int IDLE_CYC = IDLE_PERIODS * 2 * HALF_CYC;
  localparam int WAIT_MAX = (IDLE_CYC > SETTLE_CYC) ? IDLE_CYC : SETTLE_CYC;
  localparam int WW       = $clog2(WAIT_MAX + 1);
  localparam int BW       = $clog2(PKT_BITS + 1);
  localparam int DVW      = $clog2(NUM_DEV + 1);
  localparam int GW       = $clog2(GS_COUNT + 1);

  chainPhase_e    phaseQ, phaseD;
  chainMode_e     modeQ;
  logic [BW-1:0]  bitCnt;
  logic [DVW-1:0] devCnt;
  logic [WW-1:0]  waitCnt;
  logic [GW-1:0]  gsCnt;
  logic [GW-1:0]  gsTarget;
  logic           lastBit, lastDev, extMode;

  assign lastBit  = (bitCnt == BW'(PKT_BITS - 1));
  assign lastDev  = (devCnt == DVW'(NUM_DEV - 1));
  assign extMode  = (modeQ == MODE_EXT_SHORT) || (modeQ == MODE_EXT_LONG);
  assign gsTarget = (modeQ == MODE_EXT_LONG) ? GW'(LEAD_COUNT) : GW'(GS_COUNT);
  assign run      = (phaseQ == PH_SHIFT) || (phaseQ == PH_GSCLK);
  assign phase    = phaseQ;

  always_comb begin
    phaseD = phaseQ;
    strobe = '0;
    case (phaseQ)
      PH_IDLE: begin
        if (bufFull) begin
          strobe.loadPkt = 1'b1;
          phaseD         = PH_SHIFT;
        end
      end
      PH_SHIFT: begin
        if (fallEv) begin
          if (lastBit && lastDev) begin
            strobe.shiftBit = 1'b1;
            phaseD          = PH_LATCH;
          end else if (lastBit && bufFull) begin
            strobe.loadPkt = 1'b1;
          end else if (lastBit) begin
            strobe.shiftBit = 1'b1;
            phaseD          = PH_STALL;
          end else begin
            strobe.shiftBit = 1'b1;
          end
        end
      end
      PH_STALL: begin
        if (bufFull) begin
          strobe.loadPkt = 1'b1;
          phaseD         = PH_SHIFT;
        end
      end
      PH_LATCH: begin
        if (waitCnt == WW'(IDLE_CYC - 1)) phaseD = extMode ? PH_SETTLE : PH_IDLE;
      end
      PH_SETTLE: begin
        if (waitCnt == WW'(SETTLE_CYC - 1)) phaseD = PH_GSCLK;
      end
      PH_GSCLK: begin
        if (fallEv && (gsCnt == gsTarget - GW'(1))) phaseD = PH_IDLE;
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      modeQ  <= MODE_INTOSC;
      bitCnt <= '0;
      devCnt <= '0;
    end else begin
      phaseQ <= phaseD;
      if (phaseQ == PH_IDLE && strobe.loadPkt) begin
        modeQ  <= chainMode_e'(modeIn);
        devCnt <= '0;
        bitCnt <= '0;
      end else if (strobe.loadPkt) begin
        devCnt <= devCnt + DVW'(1);
        bitCnt <= '0;
      end else if (phaseQ == PH_SHIFT && fallEv) begin
        bitCnt <= bitCnt + BW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || phaseD != phaseQ) begin
      waitCnt <= '0;
    end else if (phaseQ == PH_LATCH || phaseQ == PH_SETTLE) begin
      waitCnt <= waitCnt + WW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || phaseQ != PH_GSCLK) begin
      gsCnt <= '0;
    end else if (fallEv) begin
      gsCnt <= gsCnt + GW'(1);
    end
  end
endmodule

// File: rtl/ledchain_sequencer.sv
module ledchain_sequencer
  import ledchain_pkg::*;
#(
  parameter int NUM_DEV       = 256,
  parameter int HALF_CYC      = 4,
  parameter int IDLE_PERIODS  = 8,
  parameter int SYS_PERIOD_PS = 10000,
  parameter int SETTLE_PS     = 1340000,
  parameter int GS_COUNT      = 65536
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   modeSel,
  input  logic         pktValid,
  input  logic [217:0] pktData,
  output logic         pktReady,
  output logic         sclkOut,
  output logic         sdoOut
);
  localparam int SETTLE_CYC = (SETTLE_PS + SYS_PERIOD_PS - 1) / SYS_PERIOD_PS;
  localparam int LEAD_COUNT = GS_COUNT - NUM_DEV * PKT_BITS;

  dpStrobe_t   strobe;
  chainPhase_e ctrlPhase;
  logic        run, fallEv, bufFull;

  ledchain_ctrl #(
    .NUM_DEV(NUM_DEV), .HALF_CYC(HALF_CYC), .IDLE_PERIODS(IDLE_PERIODS),
    .SETTLE_CYC(SETTLE_CYC), .GS_COUNT(GS_COUNT), .LEAD_COUNT(LEAD_COUNT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeIn(modeSel), .bufFull(bufFull),
    .fallEv(fallEv), .run(run), .strobe(strobe), .phase(ctrlPhase)
  );

  ledchain_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
    .clk(clk), .rstN(rstN), .run(run), .sclk(sclkOut), .fallEv(fallEv)
  );

  ledchain_datapath u_dp (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktData(pktData),
    .strobe(strobe), .pktReady(pktReady), .bufFull(bufFull), .sdo(sdoOut)
  );
endmodule

// File: rtl/ledchain_sequencer_chk.sv
module ledchain_sequencer_chk
  import ledchain_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input logic        clk,
  input logic        rstN,
  input logic        sclkOut,
  input logic        sdoOut,
  input logic        pktValid,
  input logic        pktReady,
  input chainPhase_e ctrlPhase
);
  logic [15:0] highLen;

  always_ff @(posedge clk) begin
    if (!rstN || !sclkOut) highLen <= '0;
    else                   highLen <= highLen + 16'd1;
  end

  p_sdo_stable_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    sclkOut |-> $stable(sdoOut));

  p_high_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclkOut) |-> (highLen == 16'(HALF_CYC)));

  p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktReady) |=> !pktReady);

  p_stall_clock_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlPhase == PH_STALL) |-> !sclkOut);

  p_latch_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlPhase == PH_LATCH) |-> (!sclkOut && !sdoOut));

  p_gs_data_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlPhase == PH_GSCLK || ctrlPhase == PH_SETTLE) |-> !sdoOut);
endmodule

bind ledchain_sequencer ledchain_sequencer_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .sclkOut(sclkOut), .sdoOut(sdoOut),
  .pktValid(pktValid), .pktReady(pktReady), .ctrlPhase(ctrlPhase)
);

// File: tb/ledchain_sequencer_bench.sv
module ledchain_sequencer_bench;
  localparam int ND = 2;
  localparam int HC = 2;
  localparam int GS = 512;
  localparam int FRAME_BITS = ND * 224;
  localparam int IDLE_E = 8 * 2 * HC;
  localparam int SETTLE_E = (1340000 + 10000 - 1) / 10000;
  localparam int LEAD_E = GS - FRAME_BITS;
  localparam logic [5:0] CMD_E = 6'b100101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic pktValid = 1'b0;
  logic [217:0] pktData = '0;
  logic pktReady, sclkOut, sdoOut;

  ledchain_sequencer #(
    .NUM_DEV(ND), .HALF_CYC(HC), .IDLE_PERIODS(8),
    .SYS_PERIOD_PS(10000), .SETTLE_PS(1340000), .GS_COUNT(GS)
  ) u_ledchain_sequencer (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .pktValid(pktValid),
    .pktData(pktData), .pktReady(pktReady), .sclkOut(sclkOut), .sdoOut(sdoOut)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  logic riseBit[$];
  int riseTime[$];
  logic expBits[$];
  logic prevSclk = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference monitor: what the first device would capture on each rising edge
  always @(negedge clk) begin
    if (rstN && sclkOut && !prevSclk) begin
      riseBit.push_back(sdoOut);
      riseTime.push_back(cyc);
    end
    prevSclk = sclkOut;
  end

  always @(posedge clk) begin
    if (cyc == 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string msg, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  function automatic logic [217:0] mkPat(input int seed);
    logic [217:0] d;
    for (int i = 0; i < 218; i++) d[i] = (((i * seed) + (i / 5) + seed) % 7) < 3;
    d[217] = 1'b1;
    d[0]   = 1'b1;
    return d;
  endfunction

  task automatic expPkt(input logic [217:0] d);
    for (int b = 5; b >= 0; b--) expBits.push_back(CMD_E[b]);
    for (int b = 217; b >= 0; b--) expBits.push_back(d[b]);
  endtask

  task automatic expZeros(input int n);
    for (int k = 0; k < n; k++) expBits.push_back(1'b0);
  endtask

  task automatic sendPkt(input logic [217:0] d);
    @(negedge clk);
    pktValid = 1'b1;
    pktData  = d;
    while (!pktReady) @(negedge clk);
    @(negedge clk);
    pktValid = 1'b0;
  endtask

  task automatic clearLog();
    riseBit.delete();
    riseTime.delete();
    expBits.delete();
  endtask

  task automatic waitQuiet(input int n);
    int quiet = 0;
    int lastSize = riseBit.size();
    while (quiet < n) begin
      @(negedge clk);
      if (riseBit.size() != lastSize) begin
        lastSize = riseBit.size();
        quiet = 0;
      end else begin
        quiet++;
      end
    end
  endtask

  task automatic checkBits(input string tag);
    int bad = 0;
    check(riseBit.size() == expBits.size(), {tag, " clock count"}, riseBit.size(), expBits.size());
    for (int k = 0; k < expBits.size() && k < riseBit.size(); k++)
      if (riseBit[k] !== expBits[k]) bad++;
    check(bad == 0, {tag, " captured bit mismatches"}, bad, 0);
  endtask

  task automatic checkSpacing(input string tag, input int from, input int to, input int skipIdx);
    int bad = 0;
    for (int k = from + 1; k < to && k < riseTime.size(); k++)
      if (k != skipIdx && (riseTime[k] - riseTime[k-1]) != 2 * HC) bad++;
    check(bad == 0, {tag, " rising-edge spacing errors"}, bad, 0);
  endtask

  function automatic int gapAt(input int k);
    if (k <= 0 || k >= riseTime.size()) return -1;
    return riseTime[k] - riseTime[k-1];
  endfunction

  initial begin
    logic [217:0] p0, p1, p2, p3;
    p0 = mkPat(3); p1 = mkPat(11); p2 = mkPat(17); p3 = mkPat(29);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(sclkOut == 1'b0, "R1 sclk after reset", sclkOut, 0);
    check(sdoOut == 1'b0, "R1 sdo after reset", sdoOut, 0);
    check(pktReady == 1'b1, "R1 ready after reset", pktReady, 1);

    // T1: internal mode, back-to-back payloads (R2 R3 R4 R8)
    clearLog();
    modeSel = 2'b00;
    expPkt(p0); expPkt(p1);
    sendPkt(p0);
    check(pktReady == 1'b0, "R2 ready low after accept", pktReady, 0);
    sendPkt(p1);
    check(pktReady == 1'b0, "R2 buffer held while shifting", pktReady, 0);
    repeat (100) @(negedge clk);
    check(pktReady == 1'b0, "R2 buffer still held", pktReady, 0);
    waitQuiet(400);
    checkBits("R3 R8 internal frame");
    checkSpacing("R4 back-to-back", 0, FRAME_BITS, -1);
    check(sclkOut == 1'b0 && sdoOut == 1'b0, "R7 lines low after frame", {sclkOut, sdoOut}, 0);

    // T2: short external chain (R7 R9)
    clearLog();
    modeSel = 2'b01;
    expPkt(p2); expPkt(p3); expZeros(GS);
    sendPkt(p2);
    sendPkt(p3);
    waitQuiet(400);
    checkBits("R9 short chain");
    check(gapAt(FRAME_BITS) >= 2 * HC + IDLE_E + SETTLE_E, "R7 R9 latch idle plus settle gap",
          gapAt(FRAME_BITS), 2 * HC + IDLE_E + SETTLE_E);
    checkSpacing("R9 grayscale clocks", FRAME_BITS, FRAME_BITS + GS, -1);

    // T3: late second payload stalls the clock (R6)
    clearLog();
    modeSel = 2'b00;
    expPkt(p1); expPkt(p0);
    sendPkt(p1);
    repeat (1000) @(negedge clk);
    check(riseBit.size() == 224, "R6 clocks before stall", riseBit.size(), 224);
    check(sclkOut == 1'b0, "R6 clock low in stall", sclkOut, 0);
    sendPkt(p0);
    waitQuiet(400);
    checkBits("R6 stalled frame");
    check(gapAt(224) > 2 * HC, "R6 stall gap", gapAt(224), 2 * HC + 1);
    checkSpacing("R6 spacing away from stall", 0, FRAME_BITS, 224);

    // T4: long external chain, two overlapped frames (R10)
    clearLog();
    modeSel = 2'b10;
    expPkt(p0); expPkt(p1); expZeros(LEAD_E);
    expPkt(p2); expPkt(p3); expZeros(LEAD_E);
    sendPkt(p0);
    sendPkt(p1);
    sendPkt(p2);
    sendPkt(p3);
    waitQuiet(400);
    checkBits("R10 long chain two frames");
    check(gapAt(FRAME_BITS) >= 2 * HC + IDLE_E + SETTLE_E, "R10 settle before lead-in",
          gapAt(FRAME_BITS), 2 * HC + IDLE_E + SETTLE_E);
    checkSpacing("R10 lead-in clocks", FRAME_BITS, FRAME_BITS + LEAD_E, -1);
    check(LEAD_E + FRAME_BITS == GS, "R10 display period total", LEAD_E + FRAME_BITS, GS);

    // T5: mode change mid-frame ignored (R11)
    clearLog();
    modeSel = 2'b01;
    expPkt(p3); expPkt(p2); expZeros(GS);
    sendPkt(p3);
    repeat (5) @(negedge clk);
    modeSel = 2'b00;
    sendPkt(p2);
    waitQuiet(400);
    checkBits("R11 mode held through frame");

    // T6: mode 11 behaves as internal (R8)
    clearLog();
    modeSel = 2'b11;
    expPkt(p2); expPkt(p0);
    sendPkt(p2);
    sendPkt(p0);
    waitQuiet(400);
    checkBits("R8 mode 11 no trailing clocks");
    check(pktReady == 1'b1, "R2 ready after frame", pktReady, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule